// File: doc/BRIEF.md
# Serial PCM Timeslot Port

This block is the digital half of a telephony codec's serial highway port. It runs on the 2.048 MHz bit clock. A frame enable, active low, opens one 8-bit timeslot per frame, but only when a 2-bit channel-address code selects PCM traffic. During that slot the port sends a PCM byte, MSB first, on an output that carries a separate drive-enable for tri-state. It also shifts in the byte arriving on the serial input.

Bytes move out on rising clock edges and are captured on falling edges. The outgoing byte comes from the encoder in sign-magnitude form, and one of three line code formats is applied to it. Each received byte is handed to the decoder on a held register, together with a one-cycle valid pulse.

A digital-loopback control sends the last received byte back out unchanged. In that mode the decoder is fed zero. A powerdown control keeps the output undriven. The analog filters and converters are outside this block and are stood in for by byte-wide ports.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is high, and directly after it, `dout_oe` is 0, `dec_byte` is 0 and `dec_valid` is 0.
- R2: On the first rising edge at which `frame_n` is sampled low and PCM is selected, `dout_oe` goes to 1 and `dout` carries bit 7 (the sign) of the outgoing word. Each of the next seven rising edges drives the next lower bit.
- R3: `dout_oe` returns to 0 on the rising edge after the eighth bit, even if `frame_n` stays low. It also returns to 0 on any rising edge at which `frame_n` is sampled high. A single low period of `frame_n` opens at most one slot.
- R4: `chan_sel` codes 00 and 01 select PCM. Codes 10 and 11 inhibit the slot: `dout_oe` stays 0, no byte is captured and `dec_valid` does not pulse.
- R5: `din` is captured on falling edges. The first falling edge after the slot opens takes bit 7. After the eighth capture, `dec_byte` is updated and `dec_valid` is 1 for exactly one clock period.
- R6: `code_fmt` 00 sends `enc_byte` unchanged (sign-magnitude). Code 11 behaves the same way.
- R7: `code_fmt` 01 keeps the sign bit and inverts bits 6..0 (XOR 0x7F).
- R8: `code_fmt` 10 inverts the even bits 0, 2, 4 and 6 (XOR 0x55).
- R9: With `loopback` at 1, the slot sends the most recently received byte without any format conversion, and `enc_byte` is ignored.
- R10: With `loopback` at 1, `dec_byte` is held at 0, and the received byte is still kept for the loopback path.
- R11: While `pwrdn` is 1, `dout_oe` stays 0 whatever `frame_n` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 2.048 MHz bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Frame/slot enable, active low, sampled on rising edges |
| chan_sel | input | 2 | Channel address: 00 low, 01 ground, 10/11 high |
| pwrdn | input | 1 | Powerdown; forces the output undriven |
| loopback | input | 1 | Digital loopback select |
| code_fmt | input | 2 | Output code format select |
| enc_byte | input | 8 | Encoder result, sign-magnitude |
| din | input | 1 | Serial PCM input |
| dout | output | 1 | Serial PCM output data |
| dout_oe | output | 1 | Drive enable for the tri-state output |
| dec_byte | output | 8 | Byte presented to the decoder |
| dec_valid | output | 1 | One-cycle pulse when dec_byte updates |

## Verification
The bench checks every serial bit against the edge on which it should appear. An error of one edge in the start of output or in the first capture therefore shows up as a shifted byte. It also holds the frame enable low past the eighth bit, which catches a port that keeps driving or opens a second slot. It drives the inhibiting channel codes and checks for no output, no valid pulse and an unchanged decoder byte. It walks all four format codes, so a wrong inversion mask shows up directly. In loopback it checks that the previous frame's byte comes back unformatted and that the decoder sees zero.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    FMT_SIGNMAG = 2'b00,
    FMT_MAGINV  = 2'b01,
    FMT_ALTINV  = 2'b10,
    FMT_SPARE   = 2'b11
  } code_fmt_e;

  // Channel address codes 00 (low) and 01 (ground) carry PCM; 1x is high.
  function automatic logic pcm_selected(input logic [1:0] ch);
    return ~ch[1];
  endfunction
endpackage

// File: rtl/pcm_code_fmt.sv
module pcm_code_fmt #(
  parameter int W = 8
) (
  input  logic [W-1:0] raw,
  input  logic [1:0]   fmt,
  output logic [W-1:0] coded
);
  import pcm_pkg::*;

  logic [W-1:0] mag_mask;
  logic [W-1:0] alt_mask;

  generate
    for (genvar i = 0; i < W; i++) begin : g_mask
      assign mag_mask[i] = (i != W-1);
      assign alt_mask[i] = ((i % 2) == 0);
    end
  endgenerate

  always_comb begin
    case (fmt)
      FMT_MAGINV: coded = raw ^ mag_mask;
      FMT_ALTINV: coded = raw ^ alt_mask;
      default:    coded = raw;
    endcase
  end
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_n,
  input  logic [1:0]   chan_sel,
  input  logic         pwrdn,
  input  logic [W-1:0] word,
  output logic         slot_o,
  output logic         dout,
  output logic         dout_oe
);
  import pcm_pkg::*;
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W-1);
  localparam int RW = $clog2(W + 2);

  logic          slot_q, done_q, dout_q, oe_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= 1'b0;
      done_q <= 1'b0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else if (frame_n) begin
      slot_q <= 1'b0;
      done_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (!slot_q && !done_q) begin
      if (pcm_selected(chan_sel)) begin
        slot_q <= 1'b1;
        cnt_q  <= '0;
        dout_q <= word[W-1];
        sh_q   <= word << 1;
        oe_q   <= ~pwrdn;
      end else begin
        done_q <= 1'b1;
      end
    end else if (slot_q) begin
      if (cnt_q == LAST) begin
        slot_q <= 1'b0;
        done_q <= 1'b1;
        oe_q   <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        dout_q <= sh_q[W-1];
        sh_q   <= sh_q << 1;
        oe_q   <= ~pwrdn;
      end
    end
  end

  assign slot_o  = slot_q;
  assign dout    = dout_q;
  assign dout_oe = oe_q;

  // Checker state: length of the current drive run.
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !oe_q) run_q <= '0;
    else              run_q <= run_q + 1'b1;
  end

  a_r3_drive_len: assert property (@(posedge clk) disable iff (rst)
    run_q <= RW'(W));
  a_r3_frame_high_stops: assert property (@(posedge clk) disable iff (rst)
    frame_n |=> !dout_oe);
  a_r11_pwrdn_quiet: assert property (@(posedge clk) disable iff (rst)
    pwrdn |=> !dout_oe);
  a_r4_start_needs_pcm: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> (!$past(frame_n) && !$past(chan_sel[1])));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slot_i,
  input  logic         din,
  input  logic         loopback,
  output logic [W-1:0] hold_o,
  output logic [W-1:0] dec_byte,
  output logic         dec_valid
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W-1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q, hold_q, dec_q;
  logic          vld_q;
  logic [W-1:0]  next_sh;

  assign next_sh = {sh_q[W-2:0], din};

  always_ff @(negedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      hold_q <= '0;
      dec_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (slot_i) begin
        sh_q  <= next_sh;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          hold_q <= next_sh;
          vld_q  <= 1'b1;
          dec_q  <= loopback ? '0 : next_sh;
          cnt_q  <= '0;
        end
      end else begin
        cnt_q <= '0;
      end
      if (loopback) dec_q <= '0;
    end
  end

  assign hold_o    = hold_q;
  assign dec_byte  = dec_q;
  assign dec_valid = vld_q;

  a_r5_valid_single: assert property (@(negedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
  a_r10_loop_dec_zero: assert property (@(negedge clk) disable iff (rst)
    loopback |=> (dec_byte == '0));
  a_r5_valid_in_slot: assert property (@(negedge clk) disable iff (rst)
    $rose(dec_valid) |-> $past(slot_i));
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_n,
  input  logic [1:0]   chan_sel,
  input  logic         pwrdn,
  input  logic         loopback,
  input  logic [1:0]   code_fmt,
  input  logic [W-1:0] enc_byte,
  input  logic         din,
  output logic         dout,
  output logic         dout_oe,
  output logic [W-1:0] dec_byte,
  output logic         dec_valid
);
  logic [W-1:0] coded, rx_hold, tx_word;
  logic         slot;

  pcm_code_fmt #(.W(W)) fmt_i (
    .raw   (enc_byte),
    .fmt   (code_fmt),
    .coded (coded)
  );

  assign tx_word = loopback ? rx_hold : coded;

  pcm_tx_slot #(.W(W)) tx_i (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .chan_sel (chan_sel),
    .pwrdn    (pwrdn),
    .word     (tx_word),
    .slot_o   (slot),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  pcm_rx_slot #(.W(W)) rx_i (
    .clk       (clk),
    .rst       (rst),
    .slot_i    (slot),
    .din       (din),
    .loopback  (loopback),
    .hold_o    (rx_hold),
    .dec_byte  (dec_byte),
    .dec_valid (dec_valid)
  );
endmodule

// File: tb/pcm_slot_port_tb_top.sv
module pcm_slot_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1;
  logic [1:0] chan_sel = 2'b00;
  logic pwrdn = 1'b0;
  logic loopback = 1'b0;
  logic [1:0] code_fmt = 2'b00;
  logic [7:0] enc_byte = 8'h00;
  logic din = 1'b0;
  logic dout, dout_oe, dec_valid;
  logic [7:0] dec_byte;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pcm_slot_port #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .chan_sel(chan_sel),
    .pwrdn(pwrdn), .loopback(loopback), .code_fmt(code_fmt),
    .enc_byte(enc_byte), .din(din), .dout(dout), .dout_oe(dout_oe),
    .dec_byte(dec_byte), .dec_valid(dec_valid)
  );

  typedef struct packed {
    logic [1:0] fmt;
    logic       lb;
    logic [1:0] ch;
    logic [7:0] enc;
    logic [7:0] rx;
    logic [7:0] tx;
    logic       act;
    logic [7:0] dec;
  } row_t;

  localparam int NROW = 10;
  localparam row_t TBL [NROW] = '{
    '{2'd0, 1'b0, 2'b00, 8'hA5, 8'h3C, 8'hA5, 1'b1, 8'h3C}, // R6
    '{2'd1, 1'b0, 2'b01, 8'hA5, 8'hC3, 8'hDA, 1'b1, 8'hC3}, // R7
    '{2'd2, 1'b0, 2'b00, 8'h12, 8'h81, 8'h47, 1'b1, 8'h81}, // R8
    '{2'd3, 1'b0, 2'b00, 8'h80, 8'h7E, 8'h80, 1'b1, 8'h7E}, // R6 spare code
    '{2'd0, 1'b0, 2'b10, 8'hFF, 8'h11, 8'h00, 1'b0, 8'h7E}, // R4
    '{2'd0, 1'b0, 2'b11, 8'h0F, 8'h22, 8'h00, 1'b0, 8'h7E}, // R4
    '{2'd1, 1'b1, 2'b00, 8'h55, 8'h99, 8'h7E, 1'b1, 8'h00}, // R9 R10
    '{2'd2, 1'b1, 2'b01, 8'h00, 8'h44, 8'h99, 1'b1, 8'h00}, // R9 R10
    '{2'd2, 1'b0, 2'b00, 8'hFF, 8'h5A, 8'hAA, 1'b1, 8'h5A}, // R8 R5
    '{2'd1, 1'b0, 2'b00, 8'h00, 8'hFF, 8'h7F, 1'b1, 8'hFF}  // R7
  };

  task automatic chk(input logic ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Open a slot and walk its eight bits. Frame_n is lowered before the call.
  task automatic walk_slot(input logic [7:0] rxb, input logic [7:0] txe,
                           input logic act, input string req);
    @(posedge clk); #2;
    for (int i = 7; i >= 0; i--) begin
      chk(dout_oe === act, {req, " R2 drive enable"}, {7'd0, dout_oe}, {7'd0, act});
      if (act) chk(dout === txe[i], {req, " R2 serial bit"}, {7'd0, dout}, {7'd0, txe[i]});
      din = rxb[i];
      if (i > 0) begin
        @(posedge clk); #2;
      end
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(dout_oe === 1'b0, "R1 oe in reset", {7'd0, dout_oe}, 8'd0);
    chk(dec_byte === 8'h00, "R1 dec in reset", dec_byte, 8'h00);
    chk(dec_valid === 1'b0, "R1 valid in reset", {7'd0, dec_valid}, 8'd0);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk(dout_oe === 1'b0, "R1 oe after reset", {7'd0, dout_oe}, 8'd0);

    for (int r = 0; r < NROW; r++) begin
      @(negedge clk); #2;
      code_fmt = TBL[r].fmt;
      loopback = TBL[r].lb;
      chan_sel = TBL[r].ch;
      enc_byte = TBL[r].enc;
      frame_n  = 1'b0;
      walk_slot(TBL[r].rx, TBL[r].tx, TBL[r].act, $sformatf("row%0d", r));
      @(negedge clk); #2;
      chk(dec_valid === TBL[r].act, "R5 valid pulse", {7'd0, dec_valid}, {7'd0, TBL[r].act});
      chk(dec_byte === TBL[r].dec, "R5 R10 decoder byte", dec_byte, TBL[r].dec);
      frame_n = 1'b1;
      @(posedge clk); #2;
      chk(dout_oe === 1'b0, "R3 oe after slot", {7'd0, dout_oe}, 8'd0);
      @(negedge clk); #2;
      chk(dec_valid === 1'b0, "R5 valid one cycle", {7'd0, dec_valid}, 8'd0);
      repeat (2) @(posedge clk);
    end

    // R3: frame held low past the slot opens nothing further
    @(negedge clk); #2;
    loopback = 1'b0; code_fmt = 2'd0; chan_sel = 2'b00; enc_byte = 8'h3C;
    frame_n = 1'b0;
    walk_slot(8'h66, 8'h3C, 1'b1, "hold-low");
    @(posedge clk); #2;
    chk(dout_oe === 1'b0, "R3 ninth edge releases", {7'd0, dout_oe}, 8'd0);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #2;
      chk(dout_oe === 1'b0, "R3 no second slot", {7'd0, dout_oe}, 8'd0);
    end
    chk(dec_byte === 8'h66, "R5 hold-low capture", dec_byte, 8'h66);
    frame_n = 1'b1;
    repeat (2) @(posedge clk);

    // R11: powerdown keeps the output undriven
    @(negedge clk); #2;
    pwrdn = 1'b1; enc_byte = 8'hFF;
    frame_n = 1'b0;
    walk_slot(8'h00, 8'h00, 1'b0, "R11 powerdown");
    @(negedge clk); #2;
    frame_n = 1'b1;
    pwrdn = 1'b0;
    repeat (2) @(posedge clk);

    // R2 again after powerdown released
    @(negedge clk); #2;
    code_fmt = 2'd0; enc_byte = 8'h01; frame_n = 1'b0;
    walk_slot(8'h10, 8'h01, 1'b1, "post-pwrdn");
    @(negedge clk); #2;
    chk(dec_byte === 8'h10, "R5 post-pwrdn capture", dec_byte, 8'h10);
    frame_n = 1'b1;
    repeat (2) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule